// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block makes a programmable periodic event from a 32.768 kHz time base. That time base arrives as a one-clock strobe, `tick`, in the system clock domain. A counter that never stops advances on every strobe. An event fires on the strobe that brings that counter to a whole multiple of the selected period. Because of this, events stay on the same grid when the rate code changes, and also when the generator is switched off and on again. The grid does not restart from the moment of the write.

Two outputs carry the event. The first is a one-clock set mask for the interrupt-status register, which the status register ORs into its contents. The second is a pulse on the square-wave pin that lasts exactly one tick. Each output is used only when its own enable allows it. The rate code is decoded non-linearly. Code 0 switches the event off. The two lowest non-zero codes stand for long periods.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, `flag_set` is 0 and `sqw_pulse` is 0. The free-running tick counter starts at 0, so the first event lands on the strobe numbered by the period (for example the 4th strobe for code 3).
- R2: For a code c from 3 to 15, the period is 2^(c-1) ticks.
- R3: Code 1 gives a period of 128 ticks and code 2 gives a period of 256 ticks.
- R4: Code 0 produces no event on either output.
- R5: The generator runs only when `pie_en` is 1, or when both `sqw_en` and `sqw_present` are 1. While it is stopped the counter keeps counting, so events resume on the original grid.
- R6: An event occurs on the strobe after which the tick count is a multiple of the current period. After a rate change, the next event is the next multiple of the new period.
- R7: On an event with `pie_en` = 1, `flag_set` equals 8'hC0 (bit 7 is the interrupt request, bit 6 is the periodic flag) for exactly one clock, the clock after the strobe. At all other times it is 0.
- R8: On an event with `sqw_en` = 1 and `sqw_present` = 1, `sqw_pulse` goes high the clock after the strobe. It stays high until the clock after the next strobe, which is one tick.
- R9: With `pie_en` = 1 and `sqw_en` = 0, no square-wave pulse appears. With `sqw_en` = 1, `sqw_present` = 1 and `pie_en` = 0, `flag_set` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe at 32.768 kHz |
| rate_code | input | 4 | Rate-select code |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_present | input | 1 | Square-wave pin is connected |
| flag_set | output | 8 | Status set mask, 8'hC0 for one clock per event |
| sqw_pulse | output | 1 | One-tick pulse per event |

## Verification
Both outputs are registered once after the strobe. The results of a strobe at one clock edge are therefore due one clock later. The bench raises `tick` between edges and samples at the falling edge that follows the capturing edge. It then idles one clock and samples again, to confirm that `flag_set` has dropped and `sqw_pulse` is holding. The bench keeps its own count of strobes. The expected event for every strobe comes from the period rule, so phase alignment is checked across rate changes and while the generator is disabled.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W = 16,
  parameter logic [7:0] SET_MASK = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] rate_code,
  input  logic       pie_en,
  input  logic       sqw_en,
  input  logic       sqw_present,
  output logic [7:0] flag_set,
  output logic       sqw_pulse
);

  localparam logic [3:0] ALIAS_OFS = 4'd7;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] mask;
  logic [3:0]       eff;
  logic             sqw_ok;
  logic             run;
  logic             evt;

  assign eff    = (rate_code == 4'd1 || rate_code == 4'd2) ? rate_code + ALIAS_OFS : rate_code;
  assign mask   = (CNT_W'(1) << (eff - 4'd1)) - CNT_W'(1);
  assign sqw_ok = sqw_en && sqw_present;
  assign run    = (rate_code != 4'd0) && (pie_en || sqw_ok);
  assign nxt    = cnt + CNT_W'(1);
  assign evt    = tick && run && ((nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      flag_set  <= '0;
      sqw_pulse <= 1'b0;
    end else begin
      if (tick) cnt <= nxt;
      flag_set <= (evt && pie_en) ? SET_MASK : 8'h00;
      if (tick) sqw_pulse <= evt && sqw_ok;
    end
  end

  a_r7_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |=> (flag_set == 8'h00));

  a_r7_flag_needs_pie: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |-> $past(pie_en));

  a_r8_sqw_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_pulse) |-> $past(tick));

  a_r8_sqw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw_pulse && !tick) |=> sqw_pulse);

  a_r4_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) |=> (flag_set == 8'h00));

  a_r6_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'h00) |-> ((cnt & $past(mask)) == '0));

endmodule

// File: tb/periodic_rate_gen_test.sv
module periodic_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       sqw_present = 1'b0;
  logic [7:0] flag_set;
  logic       sqw_pulse;

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  bit done = 1'b0;

  periodic_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .sqw_present(sqw_present),
    .flag_set(flag_set), .sqw_pulse(sqw_pulse)
  );

  always #5 clk = ~clk;

  function automatic int period_of(input logic [3:0] c);
    if (c == 4'd0) return 0;
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (tick count %0d)", req, act, exp, mcnt);
    end
  endtask

  task automatic one_tick(input string req);
    int per;
    bit active;
    bit evt;
    per = period_of(rate_code);
    active = (per != 0) && (pie_en || (sqw_en && sqw_present));
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    mcnt++;
    evt = active && (mcnt % per == 0);
    check({req, " flag"}, int'(flag_set), (evt && pie_en) ? 'hC0 : 0);
    check({req, " sqw"}, int'(sqw_pulse), int'(evt && sqw_en && sqw_present));
    @(negedge clk);
    check({req, " flag drop"}, int'(flag_set), 0);
    check({req, " sqw hold"}, int'(sqw_pulse), int'(evt && sqw_en && sqw_present));
  endtask

  task automatic run_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) one_tick(req);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset flag", int'(flag_set), 0);
    check("R1 reset sqw", int'(sqw_pulse), 0);
    rst_n = 1'b1;
    mcnt = 0;
    rate_code = 4'd3; pie_en = 1'b1;
    run_ticks(8, "R1");
  endtask

  task automatic test_periods();
    pie_en = 1'b1; sqw_en = 1'b0; sqw_present = 1'b1;
    for (int c = 3; c <= 15; c++) begin
      rate_code = 4'(c);
      run_ticks(period_of(4'(c)) + 3, "R2");
    end
  endtask

  task automatic test_alias();
    pie_en = 1'b1;
    rate_code = 4'd1; run_ticks(300, "R3");
    rate_code = 4'd2; run_ticks(530, "R3");
  endtask

  task automatic test_code0();
    pie_en = 1'b1; sqw_en = 1'b1; sqw_present = 1'b1;
    rate_code = 4'd0; run_ticks(40, "R4");
  endtask

  task automatic test_enable_gate();
    rate_code = 4'd4;
    pie_en = 1'b0; sqw_en = 1'b1; sqw_present = 1'b0;
    run_ticks(21, "R5 stopped");
    pie_en = 1'b0; sqw_en = 1'b0; sqw_present = 1'b1;
    run_ticks(13, "R5 stopped");
    pie_en = 1'b1;
    run_ticks(20, "R5 resumed grid");
  endtask

  task automatic test_phase_change();
    pie_en = 1'b1; sqw_en = 1'b0;
    rate_code = 4'd3; run_ticks(5, "R6");
    rate_code = 4'd6; run_ticks(70, "R6");
    rate_code = 4'd4; run_ticks(19, "R6");
  endtask

  task automatic test_outputs_split();
    rate_code = 4'd3;
    pie_en = 1'b0; sqw_en = 1'b1; sqw_present = 1'b1;
    run_ticks(16, "R9 sqw only");
    pie_en = 1'b1; sqw_en = 1'b1; sqw_present = 1'b1;
    run_ticks(16, "R8 both");
    pie_en = 1'b1; sqw_en = 1'b0;
    run_ticks(16, "R7 pie only");
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_periods();
        test_alias();
        test_code0();
        test_enable_gate();
        test_phase_change();
        test_outputs_split();
        done = 1'b1;
      end
      begin
        repeat (190000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=hung expected=finished");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule